// File: doc/BRIEF.md
# Repeated String Move Engine

This block carries out block-memory string operations for an execution unit. It holds a source pointer, a destination pointer, an accumulator, a count register and a direction flag. A command either changes the direction flag, or performs one of three element transfers: a store (accumulator to memory at the destination pointer), a load (memory at the source pointer into the accumulator) or a move (memory at the source pointer copied to the destination pointer). Elements are 1, 2, 4 or 8 bytes wide.

Each transfer steps the pointers it used by the element size after the access, upward when the direction flag is 0 and downward when it is 1. With the repeat bit set, the transfer runs once per unit of the count register and the count ends at zero. The engine talks to a single-port memory through a request/acknowledge handshake. The final register values are shown on its outputs, and a one-cycle done pulse closes every command.

Top module: `strmove_engine`

## Requirements
- R1: While reset is low at a clock edge, all pointer, accumulator and count outputs clear to zero, the direction flag clears to 0, and busy, done and the memory request are low.
- R2: A command is accepted when `cmd_valid` is high, busy is low and `cmd_op` is 0 to 4. On acceptance the source, destination, accumulator and count registers take the values of `cmd_src`, `cmd_dst`, `cmd_acc` and `cmd_cnt`. Opcode 1 sets the direction flag to 1 and opcode 0 clears it to 0, both at the accepting edge.
- R3: Store (opcode 2) writes the low element bytes of the accumulator to the destination address, with `mem_we`=1. `mem_size` carries the element code: 0, 1, 2 and 3 give 1, 2, 4 and 8 bytes.
- R4: Load (opcode 3) reads the source address with `mem_we`=0 and replaces the low element bytes of the accumulator with the read data. The higher accumulator bytes keep their value.
- R5: Move (opcode 4) uses two transactions per element. It first reads at the source address, then writes the captured read data to the destination address.
- R6: After each access, the pointer used by that access changes by the element size in bytes. It increases when the direction flag is 0 and decreases when it is 1. The pointer that was not used stays unchanged.
- R7: With `cmd_rep`=1, a string command runs exactly as many elements as the loaded count, and the count output ends at 0. With `cmd_rep`=0 it runs one element and the count keeps its loaded value.
- R8: A repeated string command whose loaded count is 0 makes no memory request, and done follows on the cycle after acceptance.
- R9: Busy is high from the cycle after acceptance up to and including the single done cycle, and then drops. A command presented while busy is high is ignored.
- R10: Once raised, the memory request holds with a stable address, write flag and size until a cycle with `mem_ack` high.
- R11: A command with opcode 5, 6 or 7 is ignored. Busy and done stay low, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Opcode: 0 clear dir, 1 set dir, 2 store, 3 load, 4 move |
| cmd_rep | input | 1 | Repeat by count |
| cmd_size | input | 2 | Element size code (bytes = 1 << code) |
| cmd_src | input | AW | Source pointer value loaded at acceptance |
| cmd_dst | input | AW | Destination pointer value loaded at acceptance |
| cmd_acc | input | DW | Accumulator value loaded at acceptance |
| cmd_cnt | input | CW | Count value loaded at acceptance |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address of the element |
| mem_size | output | 2 | Element size code |
| mem_wdata | output | DW | Write data, low bytes significant |
| mem_ack | input | 1 | Transaction complete this cycle |
| mem_rdata | input | DW | Read data, valid with ack |
| src_o | output | AW | Source pointer register |
| dst_o | output | AW | Destination pointer register |
| acc_o | output | DW | Accumulator register |
| cnt_o | output | CW | Count register |
| dir_o | output | 1 | Direction flag |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong step direction or step size changes the pointer outputs at the first acknowledged access, and the next element request then shows a wrong address on `mem_addr`. A count register that loses or gains a unit shows up at completion as a wrong number of transactions and a final count other than zero. A byte-lane error in load merging or in move data shows at the done pulse, either in the accumulator upper bytes or in the memory image. A control state that fails to leave its loop shows as a done pulse that never arrives.

// File: rtl/strmove_pkg.sv
// strmove_pkg: shared opcodes and controller state type for the string engine.
// Assumes opcodes are 3 bits wide; values above OPC_MOVE are undefined.
package strmove_pkg;
    localparam logic [2:0] OPC_DIR_CLR = 3'd0;
    localparam logic [2:0] OPC_DIR_SET = 3'd1;
    localparam logic [2:0] OPC_STORE   = 3'd2;
    localparam logic [2:0] OPC_LOAD    = 3'd3;
    localparam logic [2:0] OPC_MOVE    = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } sm_state_e;
endpackage

// File: rtl/strmove_step.sv
// strmove_step: computes a post-access pointer value, moved by the element
// size in bytes, upward for dir=0 and downward for dir=1.
// Assumes AW is at least 4 so that an 8-byte step fits.
module strmove_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] ptr,
    input  logic [1:0]    size,
    input  logic          dir,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] step_bytes;

    // step magnitude from the size code
    assign step_bytes = AW'(1) << size;
    // wrap-around add or subtract
    assign nxt = dir ? (ptr - step_bytes) : (ptr + step_bytes);
endmodule

// File: rtl/strmove_merge.sv
// strmove_merge: builds the accumulator value after a load. Byte lanes below
// the element size take the read data; higher lanes keep the old value.
// Assumes DW is a multiple of 8 and at least 64 bits.
module strmove_merge #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] rdata,
    input  logic [1:0]    size,
    output logic [DW-1:0] merged
);
    localparam int NB = DW / 8;

    logic [31:0] lane_lim;
    // number of lanes that the element covers
    assign lane_lim = 32'd1 << size;

    for (genvar lane = 0; lane < NB; lane++) begin : g_lane
        // per-lane select between read data and held accumulator
        assign merged[lane*8 +: 8] = (32'(lane) < lane_lim) ? rdata[lane*8 +: 8]
                                                            : acc[lane*8 +: 8];
    end
endmodule

// File: rtl/strmove_ctrl.sv
// strmove_ctrl: command acceptance and element sequencing. Runs read and/or
// write phases per element, loops on repeat until the count reaches its
// last unit, then emits one done cycle.
// Assumes mem_ack is only meaningful while a request is raised.
module strmove_ctrl
    import strmove_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       cmd_rep,
    input  logic       cmd_cnt_zero,
    input  logic       cnt_last,
    input  logic       mem_ack,
    output logic       accept,
    output logic       busy,
    output logic       done,
    output logic       req,
    output logic       we,
    output logic       rd_fire,
    output logic       wr_fire,
    output logic       elem_fire,
    output logic       dir_set,
    output logic       dir_clr,
    output logic [2:0] op_q,
    output logic       rep_q
);
    sm_state_e state_q, state_d;
    sm_state_e first_cmd, first_q;
    logic      op_ok;
    logic      loop_again;

    // opcode range check and state-derived outputs
    assign op_ok     = (cmd_op <= OPC_MOVE);
    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_FINISH);
    assign req       = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign we        = (state_q == ST_WRITE);
    assign accept    = cmd_valid && !busy && op_ok;
    assign dir_set   = accept && (cmd_op == OPC_DIR_SET);
    assign dir_clr   = accept && (cmd_op == OPC_DIR_CLR);
    assign rd_fire   = (state_q == ST_READ) && mem_ack;
    assign wr_fire   = (state_q == ST_WRITE) && mem_ack;
    assign elem_fire = (rd_fire && (op_q == OPC_LOAD)) || wr_fire;
    assign loop_again = rep_q && !cnt_last;

    // first phase of an element, for a new command and for a held one
    assign first_cmd = (cmd_op == OPC_STORE) ? ST_WRITE : ST_READ;
    assign first_q   = (op_q == OPC_STORE) ? ST_WRITE : ST_READ;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (cmd_op == OPC_DIR_SET || cmd_op == OPC_DIR_CLR)
                        state_d = ST_FINISH;
                    else if (cmd_rep && cmd_cnt_zero)
                        state_d = ST_FINISH;
                    else
                        state_d = first_cmd;
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    if (op_q == OPC_LOAD)
                        state_d = loop_again ? first_q : ST_FINISH;
                    else
                        state_d = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack)
                    state_d = loop_again ? first_q : ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state and latched command fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= 3'd0;
            rep_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q  <= cmd_op;
                rep_q <= cmd_rep;
            end
        end
    end

    // R9
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R11
    bad_op_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && (cmd_op > OPC_MOVE)) |=> !busy);

    // R8
    zero_rep_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_rep && cmd_cnt_zero && (cmd_op >= OPC_STORE)) |=> (done && !req));
endmodule

// File: rtl/strmove_engine.sv
// strmove_engine: string store/load/move engine with repeat and direction
// flag. Holds the pointer, accumulator and count registers, and drives a
// single-port request/acknowledge memory.
// Assumes the memory keeps mem_rdata valid in the cycle mem_ack is high.
module strmove_engine
    import strmove_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 64,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic          cmd_rep,
    input  logic [1:0]    cmd_size,
    input  logic [AW-1:0] cmd_src,
    input  logic [AW-1:0] cmd_dst,
    input  logic [DW-1:0] cmd_acc,
    input  logic [CW-1:0] cmd_cnt,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [DW-1:0] acc_o,
    output logic [CW-1:0] cnt_o,
    output logic          dir_o,
    output logic          busy,
    output logic          done
);
    localparam int NPTR = 2;

    logic [AW-1:0] src_q, dst_q;
    logic [DW-1:0] acc_q, hold_q, acc_ld;
    logic [CW-1:0] cnt_q;
    logic          dir_q;
    logic [1:0]    size_q;

    logic       accept, rd_fire, wr_fire, elem_fire, dir_set, dir_clr, rep_q;
    logic       req_w, we_w;
    logic [2:0] op_q;
    logic [AW-1:0] ptr_cur [NPTR];
    logic [AW-1:0] ptr_nxt [NPTR];

    // sequencing
    strmove_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_rep      (cmd_rep),
        .cmd_cnt_zero (cmd_cnt == '0),
        .cnt_last     (cnt_q == CW'(1)),
        .mem_ack      (mem_ack),
        .accept       (accept),
        .busy         (busy),
        .done         (done),
        .req          (req_w),
        .we           (we_w),
        .rd_fire      (rd_fire),
        .wr_fire      (wr_fire),
        .elem_fire    (elem_fire),
        .dir_set      (dir_set),
        .dir_clr      (dir_clr),
        .op_q         (op_q),
        .rep_q        (rep_q)
    );

    // pointer steppers, index 0 source and index 1 destination
    assign ptr_cur[0] = src_q;
    assign ptr_cur[1] = dst_q;
    for (genvar g = 0; g < NPTR; g++) begin : g_step
        strmove_step #(.AW(AW)) u_step (
            .ptr  (ptr_cur[g]),
            .size (size_q),
            .dir  (dir_q),
            .nxt  (ptr_nxt[g])
        );
    end

    // load lane merge
    strmove_merge #(.DW(DW)) u_merge (
        .acc    (acc_q),
        .rdata  (mem_rdata),
        .size   (size_q),
        .merged (acc_ld)
    );

    // memory request fields
    assign mem_req   = req_w;
    assign mem_we    = we_w;
    assign mem_addr  = we_w ? dst_q : src_q;
    assign mem_size  = size_q;
    assign mem_wdata = (op_q == OPC_MOVE) ? hold_q : acc_q;

    // architectural register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            acc_q  <= '0;
            hold_q <= '0;
            cnt_q  <= '0;
            dir_q  <= 1'b0;
            size_q <= 2'd0;
        end else begin
            if (dir_set)      dir_q <= 1'b1;
            else if (dir_clr) dir_q <= 1'b0;
            if (accept) begin
                src_q  <= cmd_src;
                dst_q  <= cmd_dst;
                acc_q  <= cmd_acc;
                cnt_q  <= cmd_cnt;
                size_q <= cmd_size;
            end
            if (rd_fire) begin
                src_q <= ptr_nxt[0];
                if (op_q == OPC_LOAD) acc_q  <= acc_ld;
                else                  hold_q <= mem_rdata;
            end
            if (wr_fire) dst_q <= ptr_nxt[1];
            if (elem_fire && rep_q) cnt_q <= cnt_q - CW'(1);
        end
    end

    assign src_o = src_q;
    assign dst_o = dst_q;
    assign acc_o = acc_q;
    assign cnt_o = cnt_q;
    assign dir_o = dir_q;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size)));

    // R6
    dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=>
            ((dir_o ? ($past(dst_o) - dst_o) : (dst_o - $past(dst_o))) == (AW'(1) << mem_size)));

    // R6
    src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=>
            ((dir_o ? ($past(src_o) - src_o) : (src_o - $past(src_o))) == (AW'(1) << mem_size)));

    // R7
    rep_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rep_q && (op_q >= OPC_STORE)) |-> (cnt_o == '0));

    // R7
    single_count_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rep_q) |=> $stable(cnt_o));

    // R9
    dir_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dir_o));
endmodule

// File: tb/sim_strmove_engine.sv
module sim_strmove_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 64;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic          cmd_rep = 1'b0;
    logic [1:0]    cmd_size = 2'd0;
    logic [AW-1:0] cmd_src = '0, cmd_dst = '0;
    logic [DW-1:0] cmd_acc = '0;
    logic [CW-1:0] cmd_cnt = '0;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [AW-1:0] src_o, dst_o;
    logic [DW-1:0] acc_o;
    logic [CW-1:0] cnt_o;
    logic          dir_o, busy, done;

    int n_chk = 0;
    int n_bad = 0;
    int txn = 0;
    int wait_left = 0;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic       exp_dir = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strmove_engine #(.AW(AW), .DW(DW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_rep(cmd_rep), .cmd_size(cmd_size), .cmd_src(cmd_src),
        .cmd_dst(cmd_dst), .cmd_acc(cmd_acc), .cmd_cnt(cmd_cnt),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .src_o(src_o), .dst_o(dst_o), .acc_o(acc_o),
        .cnt_o(cnt_o), .dir_o(dir_o), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder: random latency, one-cycle ack, byte image with 8-bit wrap
    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                if (wait_left == 0) begin
                    if (mem_we) begin
                        for (int i = 0; i < (1 << mem_size); i++)
                            mem[8'(mem_addr + 16'(i))] = mem_wdata[i*8 +: 8];
                    end else begin
                        for (int i = 0; i < 8; i++)
                            mem_rdata[i*8 +: 8] = mem[8'(mem_addr + 16'(i))];
                    end
                    mem_ack = 1'b1;
                    txn++;
                    wait_left = int'($urandom % 3);
                end else begin
                    wait_left--;
                end
            end
        end
    end

    // reference model on exp_mem
    task automatic model(input logic [2:0] op, input bit rep, input logic [1:0] sz,
                         inout logic [AW-1:0] s, inout logic [AW-1:0] d,
                         inout logic [DW-1:0] a, inout logic [CW-1:0] c, output int nt);
        int n;
        int nb;
        logic [7:0] tmp [8];
        nb = 1 << sz;
        nt = 0;
        if (op == 3'd1) begin exp_dir = 1'b1; return; end
        if (op == 3'd0) begin exp_dir = 1'b0; return; end
        n = rep ? int'(c) : 1;
        for (int e = 0; e < n; e++) begin
            if (op == 3'd3 || op == 3'd4) begin
                for (int i = 0; i < nb; i++) tmp[i] = exp_mem[8'(s + 16'(i))];
                if (op == 3'd3) for (int i = 0; i < nb; i++) a[i*8 +: 8] = tmp[i];
                s = exp_dir ? s - 16'(nb) : s + 16'(nb);
                nt++;
            end
            if (op == 3'd2 || op == 3'd4) begin
                for (int i = 0; i < nb; i++)
                    exp_mem[8'(d + 16'(i))] = (op == 3'd2) ? a[i*8 +: 8] : tmp[i];
                d = exp_dir ? d - 16'(nb) : d + 16'(nb);
                nt++;
            end
        end
        if (rep) c = '0;
    endtask

    task automatic run_cmd(input logic [2:0] op, input bit rep, input logic [1:0] sz,
                           input logic [AW-1:0] s, input logic [AW-1:0] d,
                           input logic [DW-1:0] a, input logic [CW-1:0] c, input bit intrude);
        logic [AW-1:0] es, ed;
        logic [DW-1:0] ea;
        logic [CW-1:0] ec;
        int nt, t0, guard, diff;
        string rt;
        es = s; ed = d; ea = a; ec = c;
        model(op, rep, sz, es, ed, ea, ec, nt);
        rt = (op == 3'd2) ? "R3" : (op == 3'd3) ? "R4" : (op == 3'd4) ? "R5" : "R2";
        t0 = txn;
        cmd_valid = 1'b1; cmd_op = op; cmd_rep = rep; cmd_size = sz;
        cmd_src = s; cmd_dst = d; cmd_acc = a; cmd_cnt = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (intrude && !done) begin
            // R9: command while busy must be ignored
            cmd_valid = 1'b1; cmd_op = 3'd1; cmd_src = ~s; cmd_dst = ~d; cmd_acc = ~a; cmd_cnt = c + 16'd7;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        guard = 0;
        while (!done && guard < 3000) begin @(negedge clk); guard++; end
        check(done === 1'b1, "R9 done arrives", {63'd0, done}, 64'd1);
        check(busy === 1'b1, "R9 busy during done", {63'd0, busy}, 64'd1);
        check(src_o === es, {rt, " R6 src"}, 64'(src_o), 64'(es));
        check(dst_o === ed, {rt, " R6 dst"}, 64'(dst_o), 64'(ed));
        check(acc_o === ea, {rt, " R4 acc"}, acc_o, ea);
        check(cnt_o === ec, "R7 count", 64'(cnt_o), 64'(ec));
        check(dir_o === exp_dir, "R2 dir flag", {63'd0, dir_o}, {63'd0, exp_dir});
        check((txn - t0) == nt, (rep && c == 0 && op >= 3'd2) ? "R8 transactions" : "R7 transactions",
              64'(txn - t0), 64'(nt));
        diff = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) diff++;
        check(diff == 0, {rt, " memory image"}, 64'(diff), 64'd0);
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R9 idle after done", {62'd0, busy, done}, 64'd0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'($urandom);
            exp_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(src_o == 0 && dst_o == 0 && acc_o == 0 && cnt_o == 0, "R1 regs clear",
              {src_o, dst_o, cnt_o, 16'(acc_o)}, 64'd0);
        check(dir_o == 0 && busy == 0 && done == 0 && mem_req == 0, "R1 flags clear",
              {60'd0, dir_o, busy, done, mem_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed cases
        run_cmd(3'd2, 1'b0, 2'd3, 16'h0010, 16'h0040, 64'h1122334455667788, 16'd9, 1'b0); // R3 qword store
        run_cmd(3'd3, 1'b0, 2'd0, 16'h0040, 16'h0000, 64'hAAAAAAAAAAAAAAAA, 16'd0, 1'b0); // R4 byte load keeps upper
        run_cmd(3'd4, 1'b1, 2'd1, 16'h0020, 16'h0080, 64'd0, 16'd4, 1'b0);               // R5 R7 word move repeat
        run_cmd(3'd1, 1'b0, 2'd0, 16'h0005, 16'h0006, 64'd7, 16'd1, 1'b0);               // R2 set dir
        run_cmd(3'd2, 1'b1, 2'd2, 16'h0000, 16'h00F0, 64'hDEADBEEFCAFEF00D, 16'd3, 1'b0); // R6 decreasing
        run_cmd(3'd3, 1'b1, 2'd0, 16'h0003, 16'h0000, 64'd0, 16'd5, 1'b0);               // R6 wrap below zero
        run_cmd(3'd4, 1'b1, 2'd3, 16'h0050, 16'h0090, 64'd0, 16'd0, 1'b0);               // R8 zero count
        run_cmd(3'd4, 1'b1, 2'd2, 16'h0030, 16'h0060, 64'h0, 16'd3, 1'b1);               // R9 intrusion
        run_cmd(3'd0, 1'b1, 2'd0, 16'h0001, 16'h0002, 64'd3, 16'd0, 1'b0);               // R2 clear dir
        run_cmd(3'd4, 1'b0, 2'd0, 16'h0011, 16'h0012, 64'd0, 16'd6, 1'b0);               // R7 single keeps count

        // R11: undefined opcode ignored
        cmd_valid = 1'b1; cmd_op = 3'd6; cmd_rep = 1'b1; cmd_cnt = 16'd2; cmd_src = 16'h1234;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (2) begin
            check(busy == 0 && done == 0 && mem_req == 0, "R11 no activity",
                  {61'd0, busy, done, mem_req}, 64'd0);
            check(src_o == 16'h0012 && cnt_o == 16'd6, "R11 regs unchanged",
                  {src_o, cnt_o, 32'd0}, {16'h0012, 16'd6, 32'd0});
            @(negedge clk);
        end

        // constrained random mix
        for (int k = 0; k < 60; k++) begin
            logic [2:0] op;
            int pick;
            pick = int'($urandom % 10);
            op = (pick == 0) ? 3'd0 : (pick == 1) ? 3'd1 : 3'(2 + ($urandom % 3));
            run_cmd(op, 1'($urandom), 2'($urandom), 16'($urandom % 256), 16'($urandom % 256),
                    {$urandom, $urandom}, 16'($urandom % 6), 1'($urandom % 4 == 0));
        end
        finish_run();
    end
endmodule